// File: doc/BRIEF.md
# Word-Copy DMA Channel Sequencer

This block is one channel of a memory-to-memory copy engine. Software programs it through a small register window. The window holds a source pointer, a destination pointer, a per-event word count, a run limit, a pause length, a constant pattern word and a control word. The channel then moves 32-bit words over a single bus master port. Each word is a read from the source followed by a write to the destination. When the pattern option is selected, the reads are skipped and the constant word is written instead.

Words move in bursts of a power-of-two length. A burst is never split: the bus stays locked from its first request until its last write is accepted. Between two bursts of the same run, the channel pauses for a programmed number of cycles. There are three start modes. In the self-starting mode, one run begins as soon as the channel is enabled. In the endless mode, every start pulse begins a run. In the counted mode, start pulses begin runs until a word budget is used up. A one-cycle completion pulse, and an optional interrupt, mark the end of each run that counts as finished.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, bm_req, bm_lock, done and irq are low, and every register offset reads 0.
- R2: Writing offset 0x04 (source) or 0x08 (destination) clears the low two bits of the value and loads it into that side's working pointer. Reading the same offset returns the working pointer as it advances.
- R3: Each word is a read at the source pointer followed by a write of the same data to the destination pointer. Every bus address is word aligned. A request holds its address and direction until bm_ack is seen.
- R4: Pointer update after each access: control bits [14:13] set the source and bits [11:10] set the destination. 00 adds 4, 01 subtracts 4, 10 holds the pointer, and 11 on the destination holds it.
- R5: With control [14:13] = 11, no reads are issued and every written word equals the pattern register (offset 0x18).
- R6: A burst is 2^ctrl[3:0] words, or what is left of the run if that is fewer. bm_lock is high while every request of the burst is made and falls after the burst's last write.
- R7: Between two bursts of one run, bm_req and bm_lock stay low for exactly P+1 cycles, where P is the pause register (offset 0x14).
- R8: With bit 31 (enable) and bit 28 (self-start) written together, the channel moves the per-event count (offset 0x10) of words without any start pulse. It then pulses done once and clears bit 31. The run limit and bit 29 have no effect in this mode.
- R9: With bit 29 set and bit 28 clear (endless mode), each accepted start pulse moves the per-event count of words and pulses done afterwards. Bit 31 stays set.
- R10: With bits 28 and 29 clear (counted mode), each accepted start pulse moves the per-event count of words. Once the words moved since enabling reach the run limit (offset 0x0C), done pulses and bit 31 clears. Earlier runs give no done.
- R11: A start pulse is accepted only while the channel is waiting for one. A pulse that arrives during a transfer, or in the cycle in which a run finishes, is dropped.
- R12: irq pulses together with done if control bit 30 is set, and never otherwise.
- R13: Writing the control word with bit 31 clear stops a waiting channel: later start pulses move no words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 5 | Byte offset inside the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_ofs |
| start_evt | input | 1 | Start pulse for the endless and counted modes |
| bm_req | output | 1 | Bus request |
| bm_we | output | 1 | Bus direction, 1 = write |
| bm_addr | output | 32 | Bus byte address |
| bm_wdata | output | 32 | Bus write data |
| bm_rdata | input | 32 | Bus read data, valid with bm_ack |
| bm_ack | input | 1 | Bus accepts the current request |
| bm_lock | output | 1 | Bus held for the current burst |
| done | output | 1 | One-cycle run completion pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The start pulse and the completion of a run can land in the same cycle. The finishing cycle is the one place where the channel is neither transferring nor yet waiting, so this overlap is the hazard. The bench provokes it by raising start_evt in the cycle right after it accepts the last write of an endless-mode run. It then checks the port side: the destination gets no extra words, exactly one done is counted, and a later ordinary pulse is still accepted. A second pulse is raised while a burst is on the bus, and the bench checks that it too adds no words.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // channel-relative register offsets
  localparam logic [4:0] OFS_SRC  = 5'h04;
  localparam logic [4:0] OFS_DST  = 5'h08;
  localparam logic [4:0] OFS_LIM  = 5'h0C;
  localparam logic [4:0] OFS_EVW  = 5'h10;
  localparam logic [4:0] OFS_PAU  = 5'h14;
  localparam logic [4:0] OFS_PAT  = 5'h18;
  localparam logic [4:0] OFS_CTL  = 5'h1C;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_RD, ST_WR, ST_GAP, ST_FIN
  } seq_st_e;

  typedef enum logic [1:0] {
    UPD_INC  = 2'b00,
    UPD_DEC  = 2'b01,
    UPD_HOLD = 2'b10,
    UPD_PAT  = 2'b11
  } upd_e;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       rep;
    logic       imm;
    upd_e       supd;
    upd_e       dupd;
    logic [3:0] blk_lg;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.en     = w[31];
    c.ie     = w[30];
    c.rep    = w[29];
    c.imm    = w[28];
    c.supd   = upd_e'(w[14:13]);
    c.dupd   = upd_e'(w[11:10]);
    c.blk_lg = w[3:0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[31]    = c.en;
    w[30]    = c.ie;
    w[29]    = c.rep;
    w[28]    = c.imm;
    w[14:13] = c.supd;
    w[11:10] = c.dupd;
    w[3:0]   = c.blk_lg;
    return w;
  endfunction

  // pointer after one access; hold and pattern leave it alone
  function automatic logic [31:0] step_addr(input logic [31:0] a, input upd_e m);
    case (m)
      UPD_INC: return a + 32'd4;
      UPD_DEC: return a - 32'd4;
      default: return a;
    endcase
  endfunction

  // words in the next burst: nominal size clipped by what is left
  function automatic logic [31:0] blk_take(input logic [3:0] lg, input logic [31:0] left);
    logic [31:0] nom;
    nom = 32'd1 << lg;
    return (left < nom) ? left : nom;
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_ofs,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      src_cur,
  input  logic [31:0]      dst_cur,
  input  logic             en_clr,
  output logic             src_ld,
  output logic             dst_ld,
  output logic [31:0]      ld_addr,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] evw,
  output logic [IVL_W-1:0] pau,
  output logic [31:0]      pat
);

  logic ctl_wr;

  assign src_ld  = reg_wr && (reg_ofs == OFS_SRC);
  assign dst_ld  = reg_wr && (reg_ofs == OFS_DST);
  assign ctl_wr  = reg_wr && (reg_ofs == OFS_CTL);
  assign ld_addr = {reg_wdata[31:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      lim  <= '0;
      evw  <= '0;
      pau  <= '0;
      pat  <= '0;
    end else begin
      if (reg_wr && reg_ofs == OFS_LIM) lim <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_ofs == OFS_EVW) evw <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_ofs == OFS_PAU) pau <= reg_wdata[IVL_W-1:0];
      if (reg_wr && reg_ofs == OFS_PAT) pat <= reg_wdata;
      // a software write in the same cycle wins over the self-clear
      if (ctl_wr)      ctrl    <= ctrl_from_word(reg_wdata);
      else if (en_clr) ctrl.en <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_ofs)
      OFS_SRC: reg_rdata = src_cur;
      OFS_DST: reg_rdata = dst_cur;
      OFS_LIM: reg_rdata = 32'(lim);
      OFS_EVW: reg_rdata = 32'(evw);
      OFS_PAU: reg_rdata = 32'(pau);
      OFS_PAT: reg_rdata = pat;
      OFS_CTL: reg_rdata = ctrl_to_word(ctrl);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_val,
  input  logic        step,
  input  upd_e        mode,
  output logic [31:0] cur
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (ld)   cur <= ld_val;
    else if (step) cur <= step_addr(cur, mode);
  end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] evw,
  input  logic [IVL_W-1:0] pau,
  input  logic [31:0]      pat,
  input  logic [31:0]      src_cur,
  input  logic [31:0]      dst_cur,
  input  logic             start_evt,
  input  logic             bm_ack,
  input  logic [31:0]      bm_rdata,
  output logic             bm_req,
  output logic             bm_we,
  output logic [31:0]      bm_addr,
  output logic [31:0]      bm_wdata,
  output logic             bm_lock,
  output logic             done,
  output logic             irq,
  output logic             en_clr,
  output logic             rd_done,
  output logic             wr_done,
  output logic             evt_take,
  output logic             pat_mode
);

  localparam int ACC_W = CNT_W + 1;

  seq_st_e          st;
  logic [CNT_W-1:0] run_rem;
  logic [CNT_W-1:0] blk_rem;
  logic [IVL_W-1:0] gap_cnt;
  logic [ACC_W-1:0] acc;
  logic [31:0]      data_q;
  logic             lock_q;
  logic             rep_mode;
  logic             goal_hit;
  logic             launch;
  seq_st_e          first_st;

  assign pat_mode = (ctrl.supd == UPD_PAT);
  assign rep_mode = ctrl.rep && !ctrl.imm;
  assign first_st = pat_mode ? ST_WR : ST_RD;
  assign goal_hit = (acc + ACC_W'(evw)) >= ACC_W'(lim);
  assign evt_take = (st == ST_WAIT) && ctrl.en && start_evt;
  assign launch   = evt_take || ((st == ST_OFF) && ctrl.en && ctrl.imm);

  assign bm_req   = (st == ST_RD) || (st == ST_WR);
  assign bm_we    = (st == ST_WR);
  assign bm_addr  = (st == ST_WR) ? dst_cur : src_cur;
  assign bm_wdata = pat_mode ? pat : data_q;
  assign bm_lock  = lock_q;
  assign rd_done  = (st == ST_RD) && bm_ack;
  assign wr_done  = (st == ST_WR) && bm_ack;

  assign done   = (st == ST_FIN) && (ctrl.imm || rep_mode || goal_hit);
  assign en_clr = (st == ST_FIN) && (ctrl.imm || (!rep_mode && goal_hit));
  assign irq    = done && ctrl.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      run_rem <= '0;
      blk_rem <= '0;
      gap_cnt <= '0;
      acc     <= '0;
      data_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          if (ctrl.en) begin
            acc <= '0;
            if (!ctrl.imm) st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!ctrl.en) st <= ST_OFF;
        end
        ST_RD: begin
          if (bm_ack) begin
            data_q <= bm_rdata;
            st     <= ST_WR;
          end
        end
        ST_WR: begin
          if (bm_ack) begin
            run_rem <= run_rem - 1'b1;
            blk_rem <= blk_rem - 1'b1;
            if (run_rem == CNT_W'(1)) begin
              lock_q <= 1'b0;
              st     <= ST_FIN;
            end else if (blk_rem == CNT_W'(1)) begin
              lock_q  <= 1'b0;
              gap_cnt <= pau;
              st      <= ST_GAP;
            end else begin
              st <= first_st;
            end
          end
        end
        ST_GAP: begin
          if (!ctrl.en) begin
            st <= ST_OFF;
          end else if (gap_cnt == '0) begin
            blk_rem <= CNT_W'(blk_take(ctrl.blk_lg, 32'(run_rem)));
            lock_q  <= 1'b1;
            st      <= first_st;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_FIN: begin
          acc <= acc + ACC_W'(evw);
          st  <= en_clr ? ST_OFF : ST_WAIT;
        end
        default: st <= ST_OFF;
      endcase
      if (launch) begin
        run_rem <= evw;
        blk_rem <= CNT_W'(blk_take(ctrl.blk_lg, 32'(evw)));
        lock_q  <= (evw != '0);
        st      <= (evw == '0) ? ST_FIN : first_st;
      end
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int IVL_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_ofs,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start_evt,
  output logic        bm_req,
  output logic        bm_we,
  output logic [31:0] bm_addr,
  output logic [31:0] bm_wdata,
  input  logic [31:0] bm_rdata,
  input  logic        bm_ack,
  output logic        bm_lock,
  output logic        done,
  output logic        irq
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] evw;
  logic [IVL_W-1:0] pau;
  logic [31:0]      pat;
  logic [31:0]      src_cur;
  logic [31:0]      dst_cur;
  logic [31:0]      ld_addr;
  logic             src_ld;
  logic             dst_ld;
  logic             en_clr;
  logic             rd_done;
  logic             wr_done;
  logic             evt_take;
  logic             pat_mode;
  upd_e             dst_mode;

  // a destination code of 11 behaves as hold
  assign dst_mode = (ctrl.dupd == UPD_PAT) ? UPD_HOLD : ctrl.dupd;

  dma_seq_regs #(.CNT_W(CNT_W), .IVL_W(IVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_cur(src_cur), .dst_cur(dst_cur), .en_clr(en_clr),
    .src_ld(src_ld), .dst_ld(dst_ld), .ld_addr(ld_addr),
    .ctrl(ctrl), .lim(lim), .evw(evw), .pau(pau), .pat(pat)
  );

  dma_seq_ptr u_src_ptr (
    .clk(clk), .rst_n(rst_n), .ld(src_ld), .ld_val(ld_addr),
    .step(rd_done), .mode(ctrl.supd), .cur(src_cur)
  );

  dma_seq_ptr u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .ld(dst_ld), .ld_val(ld_addr),
    .step(wr_done), .mode(dst_mode), .cur(dst_cur)
  );

  dma_seq_fsm #(.CNT_W(CNT_W), .IVL_W(IVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .lim(lim), .evw(evw),
    .pau(pau), .pat(pat), .src_cur(src_cur), .dst_cur(dst_cur),
    .start_evt(start_evt), .bm_ack(bm_ack), .bm_rdata(bm_rdata),
    .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_lock(bm_lock), .done(done), .irq(irq), .en_clr(en_clr),
    .rd_done(rd_done), .wr_done(wr_done), .evt_take(evt_take),
    .pat_mode(pat_mode)
  );

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bm_req,
  input logic        bm_we,
  input logic [31:0] bm_addr,
  input logic        bm_ack,
  input logic        bm_lock,
  input logic        done,
  input logic        irq,
  input logic        start_evt,
  input logic        evt_take,
  input logic        pat_mode
);

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> bm_addr[1:0] == 2'b00);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_ack |=> bm_req && $stable(bm_addr) && $stable(bm_we));

  assert_no_read_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && pat_mode |-> bm_we);

  assert_lock_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> bm_lock);

  assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bm_lock) |-> !bm_req);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_irq_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_evt_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_take |-> start_evt && !bm_req && !done);

endmodule

bind dma_chan_seq dma_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bm_req(bm_req), .bm_we(bm_we),
  .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_lock(bm_lock), .done(done),
  .irq(irq), .start_evt(start_evt), .evt_take(evt_take), .pat_mode(pat_mode)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_ofs = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        start_evt;
  logic        evt_task = 1'b0;
  logic        evt_fin = 1'b0;
  logic        bm_req, bm_we, bm_lock, done, irq;
  logic [31:0] bm_addr, bm_wdata;
  logic [31:0] bm_rdata = '0;
  logic        bm_ack = 1'b0;

  assign start_evt = evt_task | evt_fin;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_evt(start_evt),
    .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_rdata(bm_rdata), .bm_ack(bm_ack), .bm_lock(bm_lock),
    .done(done), .irq(irq)
  );

  logic [31:0] mem  [256];
  logic [31:0] orig [256];
  logic [31:0] expm [256];

  int nchk = 0, nfail = 0;
  int nreads, nwrites, ndone, nirq;
  int run_left = 0, bsz = 1, cur_ivl = 0;
  int blk_words = 0, blk_expect = 0, gap_len = 0;
  bit gap_pending = 0, prev_lock = 0, fin_arm = 0, fin_pend = 0, running = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_step(input logic [31:0] a, input int m, input int n);
    if (m == 0) return a + 32'(4 * n);
    if (m == 1) return a - 32'(4 * n);
    return a;
  endfunction

  function automatic logic [31:0] mk_ctrl(input int en, imm, rep, ie, sm, dm, k);
    return (32'(en) << 31) | (32'(ie) << 30) | (32'(rep) << 29) | (32'(imm) << 28)
         | (32'(sm) << 13) | (32'(dm) << 10) | 32'(k);
  endfunction

  task automatic clr_counts();
    nreads = 0; nwrites = 0; ndone = 0; nirq = 0;
  endtask

  // bus responder, block/gap monitor
  initial begin
    clr_counts();
    forever begin
      @(negedge clk);
      evt_fin = fin_pend;
      fin_pend = 0;
      if (running) begin
        if (done) ndone++;
        if (irq) nirq++;
        if (bm_lock && !prev_lock) begin
          if (gap_pending) chk(gap_len == cur_ivl + 1, "R7 pause length", gap_len, cur_ivl + 1);
          gap_pending = 0;
          blk_expect = (run_left < bsz) ? run_left : bsz;
          blk_words = 0;
        end
        if (!bm_lock && prev_lock) begin
          chk(blk_words == blk_expect, "R6 burst words", blk_words, blk_expect);
          gap_pending = (run_left > 0);
          gap_len = 0;
        end
        if (!bm_lock && gap_pending) gap_len++;
        prev_lock = bm_lock;
      end
      bm_ack = bm_req && ($urandom % 3 != 0);
      if (bm_ack) begin
        if (bm_we) begin
          mem[bm_addr[9:2]] = bm_wdata;
          nwrites++;
          run_left--;
          blk_words++;
          if (run_left == 0 && fin_arm) fin_pend = 1;
        end else begin
          bm_rdata = mem[bm_addr[9:2]];
          nreads++;
        end
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R1 watchdog: actual cycles=%0d expected fewer", WDOG_CYC);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] o, input logic [31:0] v);
    @(negedge clk);
    reg_ofs = o; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] o, output logic [31:0] v);
    @(negedge clk);
    reg_ofs = o;
    #1 v = reg_rdata;
  endtask

  task automatic fire_evt();
    @(negedge clk);
    evt_task = 1'b1;
    @(negedge clk);
    evt_task = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (nwrites < n) @(negedge clk);
  endtask

  task automatic prep(input int k, input int ivl);
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; orig[i] = mem[i]; end
    clr_counts();
    bsz = 1 << k; cur_ivl = ivl; gap_pending = 0; running = 1;
  endtask

  // mode: 0 self-start, 1 endless, 2 counted
  task automatic run_case(input int mode, sm, dm, k, ivl, w, nevt_in, ie,
                          input logic [31:0] s0, input logic [31:0] d0);
    int t, n, mism, exp_done, nevt;
    logic [31:0] fillv, v, sa, da;
    string mtag;
    nevt = (mode == 0) ? 1 : nevt_in;
    prep(k, ivl);
    fillv = $urandom;
    t = (mode == 2) ? (nevt - 1) * w + 1 + int'($urandom % w) : 1;
    wr_reg(5'h04, s0); wr_reg(5'h08, d0); wr_reg(5'h0C, 32'(t));
    wr_reg(5'h10, 32'(w)); wr_reg(5'h14, 32'(ivl)); wr_reg(5'h18, fillv);
    if (mode == 0) begin
      run_left = w;
      wr_reg(5'h1C, mk_ctrl(1, 1, int'($urandom % 2), ie, sm, dm, k));
      wait_writes(w);
    end else begin
      wr_reg(5'h1C, mk_ctrl(1, 0, (mode == 1) ? 1 : 0, ie, sm, dm, k));
      idle(2);
      for (int e = 0; e < nevt; e++) begin
        run_left = w;
        fire_evt();
        wait_writes((e + 1) * w);
        idle(3);
      end
    end
    idle(4);
    n = nevt * w;
    for (int i = 0; i < 256; i++) expm[i] = orig[i];
    for (int i = 0; i < n; i++) begin
      sa = f_step({s0[31:2], 2'b00}, (sm == 3) ? 2 : sm, i);
      da = f_step({d0[31:2], 2'b00}, (dm == 3) ? 2 : dm, i);
      expm[da[9:2]] = (sm == 3) ? fillv : orig[sa[9:2]];
    end
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) mism++;
    chk(mism == 0, "R3 memory image mismatches", mism, 0);
    chk(nwrites == n, "R3 write count", nwrites, n);
    chk(nreads == ((sm == 3) ? 0 : n), "R5 read count", nreads, (sm == 3) ? 0 : n);
    exp_done = (mode == 1) ? nevt : 1;
    mtag = (mode == 0) ? "R8 done count" : (mode == 1) ? "R9 done count" : "R10 done count";
    chk(ndone == exp_done, mtag, ndone, exp_done);
    chk(nirq == (ie ? exp_done : 0), "R12 irq count", nirq, ie ? exp_done : 0);
    rd_reg(5'h1C, v);
    chk(v[31] == (mode == 1), "R10 enable bit after run", v[31], mode == 1);
    rd_reg(5'h04, v);
    sa = f_step({s0[31:2], 2'b00}, (sm == 3) ? 2 : sm, n);
    chk(v == sa, "R4 source pointer", v, sa);
    rd_reg(5'h08, v);
    da = f_step({d0[31:2], 2'b00}, (dm == 3) ? 2 : dm, n);
    chk(v == da, "R4 destination pointer", v, da);
    if (mode == 1) begin
      wr_reg(5'h1C, 32'h0);
      idle(3);
    end
    running = 0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bm_req && !bm_lock && !done && !irq, "R1 outputs in reset",
        {bm_req, bm_lock, done, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int o = 0; o < 32; o += 4) begin
      rd_reg(5'(o), v);
      chk(v == 0, "R1 register reads zero", v, 0);
    end
    // R2: alignment on load
    wr_reg(5'h04, 32'h0000_0107); rd_reg(5'h04, v);
    chk(v == 32'h104, "R2 source aligned", v, 32'h104);
    wr_reg(5'h08, 32'h0000_020B); rd_reg(5'h08, v);
    chk(v == 32'h208, "R2 destination aligned", v, 32'h208);

    // directed: self-start with bursts and pauses (R6 R7 R8)
    run_case(0, 0, 0, 2, 3, 10, 1, 1, 32'h0000_0043, 32'h0000_0202);
    // directed: pattern fill, decrementing destination (R5)
    run_case(0, 3, 1, 0, 0, 5, 1, 0, 32'h0000_0010, 32'h0000_03FC);
    // directed: counted mode, limit 10 with 4 per event (R10)
    prep(1, 1);
    wr_reg(5'h04, 32'h40); wr_reg(5'h08, 32'h240); wr_reg(5'h0C, 32'd10);
    wr_reg(5'h10, 32'd4); wr_reg(5'h14, 32'd1);
    wr_reg(5'h1C, mk_ctrl(1, 0, 0, 1, 0, 0, 1));
    idle(2);
    for (int e = 0; e < 2; e++) begin
      run_left = 4; fire_evt(); wait_writes((e + 1) * 4); idle(4);
    end
    chk(ndone == 0, "R10 no done before limit", ndone, 0);
    rd_reg(5'h1C, v);
    chk(v[31] == 1'b1, "R10 still enabled before limit", v[31], 1);
    run_left = 4; fire_evt(); wait_writes(12); idle(4);
    chk(ndone == 1 && nirq == 1, "R10 R12 done at limit", ndone + nirq, 2);
    rd_reg(5'h1C, v);
    chk(v[31] == 1'b0, "R10 enable cleared at limit", v[31], 0);
    running = 0;

    // directed: start pulse in the finishing cycle and during a burst (R11, R13)
    prep(1, 2);
    wr_reg(5'h04, 32'h80); wr_reg(5'h08, 32'h280); wr_reg(5'h10, 32'd4);
    wr_reg(5'h14, 32'd2);
    wr_reg(5'h1C, mk_ctrl(1, 0, 1, 1, 0, 0, 1));
    idle(2);
    run_left = 4; fin_arm = 1; fire_evt(); wait_writes(4); idle(6); fin_arm = 0;
    chk(nwrites == 4, "R11 pulse in finishing cycle dropped", nwrites, 4);
    chk(ndone == 1, "R9 done per run", ndone, 1);
    run_left = 4; fire_evt();
    while (!bm_req) @(negedge clk);
    fire_evt();
    wait_writes(8); idle(8);
    chk(nwrites == 8, "R11 pulse during burst dropped", nwrites, 8);
    chk(ndone == 2 && nirq == 2, "R9 R12 two runs", ndone + nirq, 4);
    rd_reg(5'h1C, v);
    chk(v[31] == 1'b1, "R9 stays enabled", v[31], 1);
    wr_reg(5'h1C, mk_ctrl(0, 0, 1, 1, 0, 0, 1));
    fire_evt(); idle(8);
    chk(nwrites == 8 && !bm_req, "R13 disabled channel idle", nwrites, 8);
    running = 0;

    // constrained random cases
    for (int c = 0; c < 10; c++) begin
      int mode, sm, dm, k, ivl, w, ne;
      logic [31:0] s0, d0;
      mode = int'($urandom % 3); sm = int'($urandom % 4); dm = int'($urandom % 3);
      k = int'($urandom % 4); ivl = int'($urandom % 5);
      w = 1 + int'($urandom % 12); ne = 1 + int'($urandom % 3);
      s0 = (sm == 1) ? 32'h1FC - 32'(4 * ($urandom % 16)) : 32'(4 * ($urandom % 16));
      d0 = (dm == 1) ? 32'h3FC - 32'(4 * ($urandom % 16)) : 32'h200 + 32'(4 * ($urandom % 16));
      run_case(mode, sm, dm, k, ivl, w, ne, int'($urandom % 2), s0, d0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule